// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Normalization and Rounding

This block multiplies two 32-bit binary floating-point operands. Each operand is split into sign, biased exponent and fraction, and the implicit leading one is put back on the fraction. The two 24-bit significands are multiplied into a 48-bit product. The biased exponents are added and the bias is taken off once. The product is normalized with at most one right shift, rounded to nearest with ties to even, and packed back into a 32-bit word. An exponent that ends up too large or too small raises a flag.

A request is one cycle of `start` with both operands valid. The significand product is formed either by a shift-add engine, which needs one cycle per significand bit, or by a single-cycle array product. A parameter picks the engine. When the product is packed, `done` goes high for one cycle. The result and the flags stay stable until the next `done`. A `start` that arrives while an operation is in flight is dropped.

An operand whose exponent field is all zeros is read as a true zero. Operands with an all-ones exponent field and operands with denormalized fractions are outside the supported input set.

Top module: `fp_mul_norm`

## Requirements
- R1: The result sign (bit 31) is the XOR of the two operand sign bits (bit 31 of each). This holds for normal, zero and underflowed results.
- R2: When the product of the significands is below 2, the result exponent field (bits 30:23) is E1 + E2 − 127, computed from the stored exponent fields, and the fraction field (bits 22:0) holds the 23 bits that follow the leading one.
- R3: When the product of the significands is 2 or more, it is shifted right by one and the exponent is raised by one, so 1.5 × 1.5 gives 0x40100000.
- R4: Rounding is to nearest, ties to even. The first dropped product bit is the guard bit, and the OR of all lower bits is the sticky bit. The kept fraction is incremented when guard is 1 and either sticky is 1 or the kept LSB is 1.
- R5: When rounding carries out of the significand, the significand becomes 1.0 and the exponent goes up by one. For example, 0x3FFFFFFE × 0x3F800001 gives 0x40000000.
- R6: When the final exponent is above 254, `overflow` is 1 and the result is the sign followed by an exponent field of 0xFF and a fraction of zero. A final exponent of exactly 254 is a normal result with no flag.
- R7: When the final exponent is below 1 (negative values included, with no wraparound), `underflow` is 1 and the result is a zero with the sign from R1. A final exponent of exactly 1 is a normal result.
- R8: When either operand has an exponent field of 0, the result is a zero with the sign from R1. Neither flag is raised in this case.
- R9: `done` is high for exactly one cycle per accepted request. It rises 25 clock edges after the edge that samples `start` with the default shift-add engine. Reset clears `done`, `result`, `overflow` and `underflow` to 0.
- R10: A `start` that arrives while an operation is in flight is ignored: it produces no extra `done` and does not change the pending result. `result`, `overflow` and `underflow` change only on a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request strobe; operands are sampled with it |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | output | 32 | Rounded product, held until the next done |
| overflow | output | 1 | Final exponent above 254 |
| underflow | output | 1 | Final exponent below 1 |
| done | output | 1 | One-cycle pulse when result and flags are updated |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- `done` never stays high for two cycles in a row.
- The raw significand product always has one of its top two bits set.
- An overflow always carries the 0xFF/zero-fraction pattern.
- An underflow or a zero operand always leaves the magnitude bits at zero, and a zero operand never raises a flag.
- A normal result never has a reserved exponent field.
- The outputs move only on `done`.

The correctness of the arithmetic can only be shown by the bench's scenarios, each of which is compared against a hand-computed word. These include:
- signs and the choice between shifting and not shifting;
- round-up on a tie with an odd LSB, no rounding on a tie with an even LSB, and round-up driven by sticky;
- the renormalization carry;
- exponents at 254/255 and 1/0/negative;
- zero operands;
- a dropped `start` while the engine is busy, and the fixed latency.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Control state of the top-level sequencer.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fpm_state_e;

endpackage

// File: rtl/fpm_unpack.sv
// Splits a packed operand and restores the implicit leading one.
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sgn,
  output logic [EXP_W-1:0]      bexp,
  output logic [FRAC_W:0]       sig,
  output logic                  is_zero
);

  always_comb begin
    sgn     = word[EXP_W+FRAC_W];
    bexp    = word[FRAC_W +: EXP_W];
    is_zero = (bexp == '0);
    sig     = {1'b1, word[FRAC_W-1:0]};
  end

endmodule

// File: rtl/fpm_sig_mult.sv
// Significand product: shift-add engine (ARRAY == 0) or single-cycle array (ARRAY != 0).
module fpm_sig_mult #(
  parameter int SIG_W = 24,
  parameter bit ARRAY = 1'b0,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIG_W-1:0]  a,
  input  logic [SIG_W-1:0]  b,
  output logic [PROD_W-1:0] prod,
  output logic              valid
);

  generate
    if (ARRAY) begin : g_array
      logic [PROD_W-1:0] prod_q, prod_d;
      logic              vld_q;

      always_comb begin
        prod_d = prod_q;
        if (load) prod_d = {{SIG_W{1'b0}}, a} * {{SIG_W{1'b0}}, b};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
          vld_q  <= 1'b0;
        end else begin
          prod_q <= prod_d;
          vld_q  <= load;
        end
      end

      assign prod  = prod_q;
      assign valid = vld_q;
    end else begin : g_shift_add
      localparam int CNT_W = $clog2(SIG_W + 1);

      logic [PROD_W-1:0] acc_q, acc_d, mcand_q, mcand_d;
      logic [SIG_W-1:0]  mplr_q, mplr_d;
      logic [CNT_W-1:0]  cnt_q, cnt_d;
      logic              run_q, run_d, vld_q, vld_d;

      always_comb begin
        acc_d   = acc_q;
        mcand_d = mcand_q;
        mplr_d  = mplr_q;
        cnt_d   = cnt_q;
        run_d   = run_q;
        vld_d   = 1'b0;
        if (load) begin
          acc_d   = '0;
          mcand_d = {{SIG_W{1'b0}}, a};
          mplr_d  = b;
          cnt_d   = CNT_W'(SIG_W);
          run_d   = 1'b1;
        end else if (run_q) begin
          acc_d   = acc_q + (mplr_q[0] ? mcand_q : '0);
          mcand_d = mcand_q << 1;
          mplr_d  = mplr_q >> 1;
          cnt_d   = cnt_q - CNT_W'(1);
          run_d   = (cnt_q != CNT_W'(1));
          vld_d   = (cnt_q == CNT_W'(1));
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q   <= '0;
          mcand_q <= '0;
          mplr_q  <= '0;
          cnt_q   <= '0;
          run_q   <= 1'b0;
          vld_q   <= 1'b0;
        end else begin
          acc_q   <= acc_d;
          mcand_q <= mcand_d;
          mplr_q  <= mplr_d;
          cnt_q   <= cnt_d;
          run_q   <= run_d;
          vld_q   <= vld_d;
        end
      end

      // The engine never reports a product while it is still stepping.
      AST_MUL_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> !run_q) else $error("valid with engine running"); // R9

      assign prod  = acc_q;
      assign valid = vld_q;
    end
  endgenerate

endmodule

// File: rtl/fpm_round.sv
// Normalize (single right shift at most), round to nearest even, range check, pack.
module fpm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int XW     = EXP_W + 2
) (
  input  logic [PROD_W-1:0]    prod,
  input  logic signed [XW-1:0] exp_sum,
  input  logic                 sgn,
  input  logic                 zero,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                 ovf,
  output logic                 unf
);

  localparam logic signed [XW-1:0] EXP_TOP = XW'(2 ** EXP_W - 2);
  localparam logic signed [XW-1:0] EXP_LOW = XW'(1);

  logic                 norm, guard, sticky, rnd_up;
  logic [SIG_W-1:0]     mant;
  logic [SIG_W:0]       mant_r;
  logic signed [XW-1:0] exp_n, exp_f;
  logic [FRAC_W-1:0]    frac;

  always_comb begin
    norm = prod[PROD_W-1];
    if (norm) begin
      mant   = prod[PROD_W-1 -: SIG_W];
      guard  = prod[FRAC_W];
      sticky = |prod[FRAC_W-1:0];
    end else begin
      mant   = prod[PROD_W-2 -: SIG_W];
      guard  = prod[FRAC_W-1];
      sticky = |prod[FRAC_W-2:0];
    end
    exp_n  = exp_sum + $signed({{(XW-1){1'b0}}, norm});
    rnd_up = guard & (sticky | mant[0]);
    mant_r = {1'b0, mant} + (SIG_W+1)'(rnd_up);
    if (mant_r[SIG_W]) begin
      frac  = mant_r[FRAC_W:1];
      exp_f = exp_n + EXP_LOW;
    end else begin
      frac  = mant_r[FRAC_W-1:0];
      exp_f = exp_n;
    end

    ovf = !zero && (exp_f > EXP_TOP);
    unf = !zero && (exp_f < EXP_LOW);

    if (zero || unf) begin
      word = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    end else if (ovf) begin
      word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word = {sgn, exp_f[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/fp_mul_norm.sv
module fp_mul_norm
  import fpm_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit ARRAY_MUL = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  overflow,
  output logic                  underflow,
  output logic                  done
);

  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic signed [XW-1:0] BIAS = XW'(2 ** (EXP_W - 1) - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              sa, sb, za, zb;
  logic [EXP_W-1:0]  ea, eb;
  logic [SIG_W-1:0]  ma, mb;

  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word(op_a), .sgn(sa), .bexp(ea), .sig(ma), .is_zero(za));
  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word(op_b), .sgn(sb), .bexp(eb), .sig(mb), .is_zero(zb));

  fpm_state_e           state_q, state_d;
  logic                 accept;
  logic                 sign_q, sign_d, zero_q, zero_d;
  logic signed [XW-1:0] exp_q, exp_d;
  logic [PROD_W-1:0]    mul_prod;
  logic                 mul_valid;
  logic [WORD_W-1:0]    rnd_word, res_q, res_d;
  logic                 rnd_ovf, rnd_unf, ovf_q, ovf_d, unf_q, unf_d;

  assign accept = start && (state_q == ST_IDLE);

  fpm_sig_mult #(.SIG_W(SIG_W), .ARRAY(ARRAY_MUL)) u_mult (
    .clk(clk), .rst_n(rst_sync), .load(accept), .a(ma), .b(mb),
    .prod(mul_prod), .valid(mul_valid));

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .prod(mul_prod), .exp_sum(exp_q), .sgn(sign_q), .zero(zero_q),
    .word(rnd_word), .ovf(rnd_ovf), .unf(rnd_unf));

  // Next state.
  always_comb begin
    state_d = state_q;
    sign_d  = sign_q;
    zero_d  = zero_q;
    exp_d   = exp_q;
    res_d   = res_q;
    ovf_d   = ovf_q;
    unf_d   = unf_q;
    if (accept) begin
      state_d = ST_BUSY;
      sign_d  = sa ^ sb;
      zero_d  = za | zb;
      exp_d   = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS;
    end else if (mul_valid) begin
      state_d = ST_IDLE;
    end
    if (mul_valid) begin
      res_d = rnd_word;
      ovf_d = rnd_ovf;
      unf_d = rnd_unf;
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      zero_q  <= 1'b0;
      exp_q   <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      sign_q  <= sign_d;
      zero_q  <= zero_d;
      exp_q   <= exp_d;
      res_q   <= res_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      done    <= mul_valid;
    end
  end

  assign result    = res_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync)
    done |=> !done) else $error("done held two cycles"); // R9

  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_sync)
    mul_valid |-> (mul_prod[PROD_W-1 -: 2] != 2'b00)) else $error("product below 1.0"); // R3

  AST_ZERO_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && zero_q) |-> (!overflow && !underflow && result[WORD_W-2:0] == '0))
    else $error("zero operand mishandled"); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && overflow) |-> (!underflow && result[FRAC_W +: EXP_W] == '1 && result[FRAC_W-1:0] == '0))
    else $error("overflow pattern wrong"); // R6

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && underflow) |-> (result[WORD_W-2:0] == '0)) else $error("underflow not zero"); // R7

  AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync)
    (done && !overflow && !underflow && !zero_q) |->
      (result[FRAC_W +: EXP_W] != '0 && result[FRAC_W +: EXP_W] != '1))
    else $error("reserved exponent on normal result"); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    !$stable(result) |-> done) else $error("result moved without done"); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_sync)
    (state_q == ST_BUSY && !mul_valid) |=> (state_q == ST_BUSY && $stable(exp_q) && $stable(sign_q)))
    else $error("request accepted while busy"); // R10

endmodule

// File: tb/tb_fp_mul_norm.sv
`timescale 1ns/1ps
module tb_fp_mul_norm;

  localparam int LATENCY = 25;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [31:0] op_a, op_b, result;
  logic        overflow, underflow, done;

  always #2 clk = ~clk;

  fp_mul_norm dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .result(result), .overflow(overflow), .underflow(underflow), .done(done));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues: expected {ovf, unf, word}, tag, sampling edge.
  logic [33:0] exp_q[$];
  string       tag_q[$];
  int          cyc_q[$];

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] w, input bit ov, input bit un, input string tag);
    @(negedge clk);
    start = 1'b1;
    op_a  = a;
    op_b  = b;
    exp_q.push_back({ov, un, w});
    tag_q.push_back(tag);
    cyc_q.push_back(cyc + 1);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare on done, check latency and single-cycle pulse.
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done)
        check(1'b0, "R9 done width", 34'd1, 34'd0);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", {overflow, underflow, result}, 34'd0);
        end else begin
          logic [33:0] e;
          string       t;
          int          c;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          c = cyc_q.pop_front();
          check({overflow, underflow, result} === e, t, {overflow, underflow, result}, e);
          check((cyc - c) == LATENCY, "R9 latency", 34'(cyc - c), 34'(LATENCY));
        end
      end
    end
    prev_done = done;
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check({overflow, underflow, result, done} == 35'd0, "R9 reset state",
          {overflow, underflow, result}, 34'd0);

    issue(32'h3FC00000, 32'h3FA00000, 32'h3FF00000, 0, 0, "R2 1.5x1.25");         drain();
    issue(32'hBFC00000, 32'h3FC00000, 32'hC0100000, 0, 0, "R1 R3 -1.5x1.5");      drain();
    issue(32'hC0400000, 32'hC0000000, 32'h40C00000, 0, 0, "R1 R3 -3x-2");         drain();
    issue(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0, "R4 tie odd rounds up"); drain();
    issue(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0, "R4 tie even kept");    drain();
    issue(32'h3FFFFFFD, 32'h3F800001, 32'h3FFFFFFF, 0, 0, "R4 sticky rounds up"); drain();
    issue(32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 0, 0, "R3 R4 max sig square"); drain();
    issue(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 0, 0, "R5 round carry");      drain();
    issue(32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0, "R6 exp 255");          drain();
    issue(32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0, "R6 R1 neg overflow");  drain();
    issue(32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0, "R6 exp 254 legal");    drain();
    issue(32'h00800000, 32'h3F000000, 32'h00000000, 0, 1, "R7 exp 0");            drain();
    issue(32'h80800000, 32'h3F000000, 32'h80000000, 0, 1, "R7 R1 signed zero");   drain();
    issue(32'h00800000, 32'h00800000, 32'h00000000, 0, 1, "R7 negative exp");     drain();
    issue(32'h00800000, 32'h3F800000, 32'h00800000, 0, 0, "R7 exp 1 legal");      drain();
    issue(32'h80000000, 32'h7F7FFFFF, 32'h80000000, 0, 0, "R8 zero x large");     drain();
    issue(32'h7F000000, 32'h00000000, 32'h00000000, 0, 0, "R8 large x zero");     drain();

    // R10: second request while busy must be dropped.
    issue(32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0, "R10 R3 first request kept");
    repeat (5) @(negedge clk);
    start = 1'b1;
    op_a  = 32'h7F000000;
    op_b  = 32'h40000000;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check(result == 32'h40100000 && !overflow, "R10 outputs held",
          {overflow, underflow, result}, {2'b00, 32'h40100000});

    finish_run();
  end

endmodule